// File: doc/BRIEF.md
# Configuration Upload Sequencer with Retry

This block is a master-side controller that loads a configuration image into a slave device through a word-oriented register bus engine. After a start request, it first does a read-modify-write of the slave's port-control register to stop transmission on every port. It then waits long enough for any frame in flight to finish. Next it writes a single cold-reset bit and waits for the slave to come back up. It then streams the image out of a local image memory in bounded bursts and reads back one status word to decide whether the load took.

A failed status word, or a bus error in any step from the reset onward, starts the attempt again at the reset write. The number of attempts is bounded. The controller reports the outcome with one-cycle `done` or `error` pulses and shows how many attempts it used. All waits are counted in clock cycles, derived from the clock frequency parameter and the wait lengths in microseconds. A bus engine sits on the command side. It takes one command at a time (direction, word address, word count), pulls write words through a valid/ready data channel, and answers every command with one response that carries an error flag and, for reads, one data word.

Top module: `cfg_upload_seq`

## Requirements
- R1: On start, the first command is a one-word read of the port-control address. The second command is a one-word write to the same address. Its data is the value read, ORed with a mask whose low NUM_PORTS bits are set.
- R2: At least DRAIN_US microseconds' worth of clock cycles pass between the response to the port-control write and the first reset command.
- R3: Each reset command is a one-word write to the reset address with exactly one data bit set: bit 3 when VARIANT is 0, bit 2 when VARIANT is 1.
- R4: At least RESET_US microseconds' worth of clock cycles pass between a successful reset response and the next command.
- R5: The image of N words goes out as write commands. The first starts at the config base address. Each count is min(CHUNK_MAX, words left), each address is the previous one plus the previous count, and N = 0 sends no image command. A one-word read of the status address follows.
- R6: The write words of each image command are the image memory words at the matching offsets, in increasing order.
- R7: The status word passes only when bit 31 is 1 and bits 30, 29 and 28 are all 0. Bits 27..0 are ignored.
- R8: A failing status, or an error response to the reset, image or status command, starts a new attempt at the reset write. The port-control register is not accessed again and no drain wait is made.
- R9: At most MAX_TRIES attempts are made. When the last one fails, `error` pulses and `attempts` reads MAX_TRIES.
- R10: An error response to either port-control command ends the run with an `error` pulse and `attempts` equal to 0.
- R11: `done` and `error` are one-cycle pulses that never coincide. `attempts` holds the count of the finished run until the next accepted start.
- R12: A start request while `busy` is high is ignored.
- R13: After reset, `busy`, `done`, `error`, `cmd_valid` and `wd_valid` are 0 and `attempts` is 0.
- R14: A command stays valid with unchanged fields until accepted, and no command or write word is offered while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, taken only while idle |
| img_len | input | IMG_AW+1 | Image length in words, sampled at start |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle success pulse |
| error | output | 1 | One-cycle failure pulse |
| attempts | output | clog2(MAX_TRIES+1) | Attempts used by the current or last run |
| img_en | output | 1 | Image memory read enable |
| img_addr | output | IMG_AW | Image memory word address |
| img_rdata | input | 32 | Image memory data, one cycle after img_en |
| cmd_valid | output | 1 | Command offered to the bus engine |
| cmd_ready | input | 1 | Bus engine accepts the command |
| cmd_write | output | 1 | 1 = write, 0 = read |
| cmd_addr | output | ADDR_W | Word address of the command |
| cmd_count | output | clog2(CHUNK_MAX+1) | Number of words |
| wd_valid | output | 1 | Write word offered |
| wd_ready | input | 1 | Bus engine takes the write word |
| wd_data | output | 32 | Write word |
| rsp_valid | input | 1 | Response to the current command |
| rsp_err | input | 1 | Response reports a bus error |
| rsp_data | input | 32 | Read data of a one-word read |

## Verification
The hardest case to reach from the ports is a retry that comes after a partial upload: a bus error on a middle image burst, or on the reset write itself. In that case the next attempt has to restart the burst plan from offset zero and skip the port-control steps. The bench's bus model injects an error response on a chosen transaction number and returns a status word that depends on how many reset writes it has seen. Each table row therefore drives a given attempt into a given failure. The bench then rebuilds the expected burst plan for the final attempt out of its transaction log. Another row supplies an image length that is an exact multiple of the burst size, and others supply zero and one word, to cover the edges of the split.

// File: rtl/cus_pkg.sv
package cus_pkg;

    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    // Status word as the slave reports it; the top four bits are decoded.
    typedef struct packed {
        logic        cfg_valid;
        logic        crc_local_bad;
        logic        id_mismatch;
        logic        crc_global_bad;
        logic [27:0] other;
    } status_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PC_RD,
        S_PC_WR,
        S_DRAIN,
        S_RST_WR,
        S_RST_WAIT,
        S_CHUNK,
        S_STAT
    } seq_state_e;

    typedef enum logic [2:0] {
        X_IDLE,
        X_CMD,
        X_FETCH,
        X_SEND,
        X_RSP
    } xact_state_e;

    function automatic logic status_ok(input word_t w);
        status_t s;
        s = status_t'(w);
        return s.cfg_valid && !s.crc_local_bad && !s.id_mismatch && !s.crc_global_bad;
    endfunction

    // Cycles covering at least 'us' microseconds at 'hz', never below one.
    function automatic longint delay_cycles(input longint hz, input longint us);
        longint c;
        c = (hz * us + 64'd999_999) / 64'd1_000_000;
        return (c < 1) ? 64'd1 : c;
    endfunction

endpackage

// File: rtl/cus_timer.sv
module cus_timer #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/cus_chunker.sv
module cus_chunker #(
    parameter int LEN_W     = 13,
    parameter int CNT_W     = 7,
    parameter int CHUNK_MAX = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             init,
    input  logic [LEN_W-1:0] len,
    input  logic             advance,
    output logic [LEN_W-1:0] offset,
    output logic [CNT_W-1:0] cur_cnt,
    output logic             last,
    output logic             empty
);
    localparam logic [LEN_W-1:0] LIMIT = LEN_W'(CHUNK_MAX);

    logic [LEN_W-1:0] remaining;
    logic [LEN_W-1:0] take;

    always_comb begin
        take    = (remaining > LIMIT) ? LIMIT : remaining;
        cur_cnt = CNT_W'(take);
        last    = (remaining <= LIMIT);
        empty   = (remaining == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            remaining <= '0;
            offset    <= '0;
        end else if (init) begin
            remaining <= len;
            offset    <= '0;
        end else if (advance) begin
            remaining <= remaining - take;
            offset    <= offset + take;
        end
    end
endmodule

// File: rtl/cus_xact.sv
module cus_xact
    import cus_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W  = 7,
    parameter int IMG_AW = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              go_wr,
    input  logic              go_use_img,
    input  logic [ADDR_W-1:0] go_addr,
    input  logic [CNT_W-1:0]  go_cnt,
    input  logic [IMG_AW-1:0] go_base,
    input  word_t             go_word,
    output logic              fin,
    output logic              fin_err,
    output word_t             fin_data,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic              cmd_write,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [CNT_W-1:0]  cmd_count,
    output logic              wd_valid,
    input  logic              wd_ready,
    output word_t             wd_data,
    input  logic              rsp_valid,
    input  logic              rsp_err,
    input  word_t             rsp_data,
    output logic              img_en,
    output logic [IMG_AW-1:0] img_addr,
    input  word_t             img_rdata
);
    xact_state_e       st;
    logic              wr_q;
    logic              img_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IMG_AW-1:0] base_q;
    word_t             word_q;
    logic [CNT_W-1:0]  idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= X_IDLE;
            wr_q   <= 1'b0;
            img_q  <= 1'b0;
            addr_q <= '0;
            cnt_q  <= '0;
            base_q <= '0;
            word_q <= '0;
            idx    <= '0;
        end else begin
            case (st)
                X_IDLE: if (go) begin
                    wr_q   <= go_wr;
                    img_q  <= go_use_img;
                    addr_q <= go_addr;
                    cnt_q  <= go_cnt;
                    base_q <= go_base;
                    word_q <= go_word;
                    idx    <= '0;
                    st     <= X_CMD;
                end
                X_CMD: if (cmd_ready)
                    st <= !wr_q ? X_RSP : (img_q ? X_FETCH : X_SEND);
                X_FETCH: st <= X_SEND;
                X_SEND: if (wd_ready) begin
                    if (idx == cnt_q - 1'b1) begin
                        st <= X_RSP;
                    end else begin
                        idx <= idx + 1'b1;
                        st  <= img_q ? X_FETCH : X_SEND;
                    end
                end
                X_RSP: if (rsp_valid) st <= X_IDLE;
                default: st <= X_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd_valid = (st == X_CMD);
        cmd_write = wr_q;
        cmd_addr  = addr_q;
        cmd_count = cnt_q;
        wd_valid  = (st == X_SEND);
        wd_data   = img_q ? img_rdata : word_q;
        img_en    = (st == X_FETCH);
        img_addr  = base_q + IMG_AW'(idx);
        fin       = (st == X_RSP) && rsp_valid;
        fin_err   = rsp_err;
        fin_data  = rsp_data;
    end
endmodule

// File: rtl/cfg_upload_seq.sv
module cfg_upload_seq
    import cus_pkg::*;
#(
    parameter longint          CLK_HZ       = 200_000_000,
    parameter longint          DRAIN_US     = 500,
    parameter longint          RESET_US     = 1000,
    parameter int              VARIANT      = 0,
    parameter int              NUM_PORTS    = 5,
    parameter int              CHUNK_MAX    = 64,
    parameter int              MAX_TRIES    = 10,
    parameter int              ADDR_W       = 24,
    parameter int              IMG_AW       = 12,
    parameter logic [ADDR_W-1:0] PORTCTL_ADDR = 24'h000040,
    parameter logic [ADDR_W-1:0] RESET_ADDR   = 24'h000080,
    parameter logic [ADDR_W-1:0] STATUS_ADDR  = 24'h000004,
    parameter logic [ADDR_W-1:0] CONFIG_ADDR  = 24'h010000
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               start,
    input  logic [IMG_AW:0]                    img_len,
    output logic                               busy,
    output logic                               done,
    output logic                               error,
    output logic [$clog2(MAX_TRIES+1)-1:0]     attempts,
    output logic                               img_en,
    output logic [IMG_AW-1:0]                  img_addr,
    input  logic [31:0]                        img_rdata,
    output logic                               cmd_valid,
    input  logic                               cmd_ready,
    output logic                               cmd_write,
    output logic [ADDR_W-1:0]                  cmd_addr,
    output logic [$clog2(CHUNK_MAX+1)-1:0]     cmd_count,
    output logic                               wd_valid,
    input  logic                               wd_ready,
    output logic [31:0]                        wd_data,
    input  logic                               rsp_valid,
    input  logic                               rsp_err,
    input  logic [31:0]                        rsp_data
);
    localparam int     CNT_W     = $clog2(CHUNK_MAX + 1);
    localparam int     TRY_W     = $clog2(MAX_TRIES + 1);
    localparam int     LEN_W     = IMG_AW + 1;
    localparam longint DRAIN_CYC = delay_cycles(CLK_HZ, DRAIN_US);
    localparam longint RESET_CYC = delay_cycles(CLK_HZ, RESET_US);
    localparam longint TMR_MAX   = (DRAIN_CYC > RESET_CYC) ? DRAIN_CYC : RESET_CYC;
    localparam int     TMR_W     = $clog2(TMR_MAX + 1);
    localparam word_t  PORT_MASK = word_t'((64'd1 << NUM_PORTS) - 64'd1);

    word_t rst_word;

    generate
        if (VARIANT == 0) begin : g_rst_bit3
            assign rst_word = word_t'(32'h8);
        end else begin : g_rst_bit2
            assign rst_word = word_t'(32'h4);
        end
    endgenerate

    seq_state_e        state;
    logic              launched;
    logic [TRY_W-1:0]  tries;
    word_t             pc_word;
    logic [LEN_W-1:0]  len_q;
    logic              done_q;
    logic              err_q;

    // transaction engine request
    logic              x_go;
    logic              x_wr;
    logic              x_img;
    logic [ADDR_W-1:0] x_addr;
    logic [CNT_W-1:0]  x_cnt;
    logic [IMG_AW-1:0] x_base;
    word_t             x_word;
    logic              x_fin;
    logic              x_err;
    word_t             x_data;

    // chunk planner and timer
    logic              ck_init;
    logic              ck_adv;
    logic [LEN_W-1:0]  ck_off;
    logic [CNT_W-1:0]  ck_cnt;
    logic              ck_last;
    logic              ck_empty;
    logic              t_load;
    logic [TMR_W-1:0]  t_val;
    logic              t_exp;

    logic bus_state;
    logic ok_fin;

    always_comb begin
        bus_state = (state == S_PC_RD) || (state == S_PC_WR) || (state == S_RST_WR) ||
                    (state == S_CHUNK) || (state == S_STAT);
        x_go   = bus_state && !launched;
        x_wr   = 1'b0;
        x_img  = 1'b0;
        x_addr = PORTCTL_ADDR;
        x_cnt  = CNT_W'(1);
        x_base = '0;
        x_word = '0;
        case (state)
            S_PC_WR: begin
                x_wr   = 1'b1;
                x_word = pc_word;
            end
            S_RST_WR: begin
                x_wr   = 1'b1;
                x_addr = RESET_ADDR;
                x_word = rst_word;
            end
            S_CHUNK: begin
                x_wr   = 1'b1;
                x_img  = 1'b1;
                x_addr = CONFIG_ADDR + ADDR_W'(ck_off);
                x_cnt  = ck_cnt;
                x_base = IMG_AW'(ck_off);
            end
            S_STAT: x_addr = STATUS_ADDR;
            default: ;
        endcase

        ok_fin  = x_fin && !x_err;
        ck_init = (state == S_RST_WR) && ok_fin;
        ck_adv  = (state == S_CHUNK) && ok_fin;
        t_load  = ((state == S_PC_WR) || (state == S_RST_WR)) && ok_fin;
        t_val   = (state == S_PC_WR) ? TMR_W'(DRAIN_CYC) : TMR_W'(RESET_CYC);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            launched <= 1'b0;
            tries    <= '0;
            pc_word  <= '0;
            len_q    <= '0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            if (x_fin)
                launched <= 1'b0;
            else if (x_go)
                launched <= 1'b1;

            case (state)
                S_IDLE: if (start) begin
                    tries <= '0;
                    len_q <= img_len;
                    state <= S_PC_RD;
                end
                S_PC_RD: if (x_fin) begin
                    if (x_err) begin
                        err_q <= 1'b1;
                        state <= S_IDLE;
                    end else begin
                        pc_word <= x_data | PORT_MASK;
                        state   <= S_PC_WR;
                    end
                end
                S_PC_WR: if (x_fin) begin
                    if (x_err) begin
                        err_q <= 1'b1;
                        state <= S_IDLE;
                    end else begin
                        state <= S_DRAIN;
                    end
                end
                S_DRAIN: if (t_exp) begin
                    tries <= TRY_W'(1);
                    state <= S_RST_WR;
                end
                S_RST_WAIT: if (t_exp)
                    state <= ck_empty ? S_STAT : S_CHUNK;
                default: begin
                    // S_RST_WR, S_CHUNK, S_STAT: bus steps that may retry
                    if (x_fin) begin
                        if (x_err || ((state == S_STAT) && !status_ok(x_data))) begin
                            if (tries == TRY_W'(MAX_TRIES)) begin
                                err_q <= 1'b1;
                                state <= S_IDLE;
                            end else begin
                                tries <= tries + 1'b1;
                                state <= S_RST_WR;
                            end
                        end else begin
                            case (state)
                                S_RST_WR: state <= S_RST_WAIT;
                                S_CHUNK:  state <= ck_last ? S_STAT : S_CHUNK;
                                default: begin
                                    done_q <= 1'b1;
                                    state  <= S_IDLE;
                                end
                            endcase
                        end
                    end
                end
            endcase
        end
    end

    assign busy     = (state != S_IDLE);
    assign done     = done_q;
    assign error    = err_q;
    assign attempts = tries;

    cus_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expired(t_exp)
    );

    cus_chunker #(.LEN_W(LEN_W), .CNT_W(CNT_W), .CHUNK_MAX(CHUNK_MAX)) u_chunker (
        .clk(clk), .rst(rst), .init(ck_init), .len(len_q), .advance(ck_adv),
        .offset(ck_off), .cur_cnt(ck_cnt), .last(ck_last), .empty(ck_empty)
    );

    cus_xact #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .IMG_AW(IMG_AW)) u_xact (
        .clk(clk), .rst(rst),
        .go(x_go), .go_wr(x_wr), .go_use_img(x_img), .go_addr(x_addr),
        .go_cnt(x_cnt), .go_base(x_base), .go_word(x_word),
        .fin(x_fin), .fin_err(x_err), .fin_data(x_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_count(cmd_count),
        .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
        .img_en(img_en), .img_addr(img_addr), .img_rdata(img_rdata)
    );
endmodule

// File: rtl/cfg_upload_seq_chk.sv
module cfg_upload_seq_chk #(
    parameter int              VARIANT     = 0,
    parameter int              CHUNK_MAX   = 64,
    parameter int              MAX_TRIES   = 10,
    parameter int              ADDR_W      = 24,
    parameter logic [ADDR_W-1:0] RESET_ADDR  = 24'h000080,
    parameter logic [ADDR_W-1:0] CONFIG_ADDR = 24'h010000
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           start,
    input logic                           busy,
    input logic                           done,
    input logic                           error,
    input logic [$clog2(MAX_TRIES+1)-1:0] attempts,
    input logic                           cmd_valid,
    input logic                           cmd_ready,
    input logic                           cmd_write,
    input logic [ADDR_W-1:0]              cmd_addr,
    input logic [$clog2(CHUNK_MAX+1)-1:0] cmd_count,
    input logic                           wd_valid,
    input logic [31:0]                    wd_data
);
    localparam logic [31:0] EXP_RST = (VARIANT == 0) ? 32'h0000_0008 : 32'h0000_0004;

    logic [ADDR_W-1:0] acc_addr;

    always_ff @(posedge clk) begin
        if (rst)
            acc_addr <= '0;
        else if (cmd_valid && cmd_ready)
            acc_addr <= cmd_addr;
    end

    a_r14_cmd_hold: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr) &&
                                    $stable(cmd_write) && $stable(cmd_count));

    a_r14_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !cmd_valid && !wd_valid);

    a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(done && error));

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
        done || error |=> !done && !error);

    a_r9_attempt_bound: assert property (@(posedge clk) disable iff (rst)
        attempts <= ($clog2(MAX_TRIES+1))'(MAX_TRIES));

    a_r3_reset_word: assert property (@(posedge clk) disable iff (rst)
        wd_valid && acc_addr == RESET_ADDR |-> wd_data == EXP_RST);

    a_r5_chunk_size: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_write && cmd_addr >= CONFIG_ADDR |->
            cmd_count != '0 && cmd_count <= ($clog2(CHUNK_MAX+1))'(CHUNK_MAX));

    a_r12_start_ignored: assert property (@(posedge clk) disable iff (rst)
        busy && start && attempts != '0 |=> attempts != '0);
endmodule

bind cfg_upload_seq cfg_upload_seq_chk #(
    .VARIANT(VARIANT), .CHUNK_MAX(CHUNK_MAX), .MAX_TRIES(MAX_TRIES),
    .ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR), .CONFIG_ADDR(CONFIG_ADDR)
) u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .error(error),
    .attempts(attempts), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_count(cmd_count),
    .wd_valid(wd_valid), .wd_data(wd_data)
);

// File: tb/cfg_upload_seq_test.sv
`timescale 1ns/1ps
module cfg_upload_seq_test;
    localparam longint HZ    = 40_000;
    localparam int     IAW   = 8;
    localparam int     CMAX  = 64;
    localparam int     TRIES = 10;
    localparam logic [23:0] A_PC  = 24'h000040;
    localparam logic [23:0] A_RST = 24'h000080;
    localparam logic [23:0] A_ST  = 24'h000004;
    localparam logic [23:0] A_CFG = 24'h010000;
    localparam longint DRAIN_CYC = (HZ * 500 + 999_999) / 1_000_000;
    localparam longint RESET_CYC = (HZ * 1000 + 999_999) / 1_000_000;
    localparam logic [31:0] GOOD = 32'h8123_4567;

    typedef struct packed {
        logic [15:0] len;
        logic [31:0] pc;
        logic [31:0] bad;
        logic [7:0]  good_at;
        logic [7:0]  err_tx;
        logic [7:0]  exp_att;
        logic        exp_err;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{16'd150, 32'h0000_0100, 32'h0000_0000, 8'd1,  8'd0, 8'd1,  1'b0},
        '{16'd64,  32'hFFFF_FFE0, 32'hC000_0000, 8'd3,  8'd0, 8'd3,  1'b0},
        '{16'd1,   32'h0000_0000, 32'h9000_0000, 8'd2,  8'd0, 8'd2,  1'b0},
        '{16'd65,  32'h0000_0003, 32'hA000_0000, 8'd2,  8'd0, 8'd2,  1'b0},
        '{16'd10,  32'h0000_0000, 32'h0FFF_FFFF, 8'd99, 8'd0, 8'd10, 1'b1},
        '{16'd0,   32'h1234_0000, 32'h0000_0000, 8'd1,  8'd0, 8'd1,  1'b0},
        '{16'd5,   32'h0000_0000, 32'h0000_0000, 8'd1,  8'd3, 8'd2,  1'b0},
        '{16'd130, 32'h0000_0000, 32'h0000_0000, 8'd1,  8'd5, 8'd2,  1'b0},
        '{16'd4,   32'h0000_0000, 32'h0000_0000, 8'd1,  8'd1, 8'd0,  1'b1},
        '{16'd3,   32'h0000_0000, 32'h0000_0000, 8'd1,  8'd5, 8'd2,  1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [IAW:0] img_len = '0;
    logic busy, done, error;
    logic [3:0] attempts;
    logic img_en;
    logic [IAW-1:0] img_addr;
    logic [31:0] img_rdata = '0;
    logic cmd_valid, cmd_write;
    logic cmd_ready = 1'b0;
    logic [23:0] cmd_addr;
    logic [6:0] cmd_count;
    logic wd_valid;
    logic wd_ready = 1'b0;
    logic [31:0] wd_data;
    logic rsp_valid = 1'b0;
    logic rsp_err = 1'b0;
    logic [31:0] rsp_data = '0;

    always #2.5 clk = ~clk;

    cfg_upload_seq #(
        .CLK_HZ(HZ), .IMG_AW(IAW), .CHUNK_MAX(CMAX), .MAX_TRIES(TRIES),
        .PORTCTL_ADDR(A_PC), .RESET_ADDR(A_RST), .STATUS_ADDR(A_ST), .CONFIG_ADDR(A_CFG)
    ) uut (
        .clk(clk), .rst(rst), .start(start), .img_len(img_len),
        .busy(busy), .done(done), .error(error), .attempts(attempts),
        .img_en(img_en), .img_addr(img_addr), .img_rdata(img_rdata),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_count(cmd_count),
        .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data)
    );

    int n_chk = 0;
    int n_err = 0;
    longint cyc = 0;

    // bus model state and transaction log
    int ph = 0, cur = 0, left = 0, wi = 0;
    int n_tx = 0, resets_seen = 0, pc_reads = 0, data_bad = 0;
    logic        tx_wr   [64];
    logic [23:0] tx_addr [64];
    int          tx_cnt  [64];
    longint      tx_cmd_cyc [64];
    longint      tx_rsp_cyc [64];
    logic [31:0] tx_w0   [64];
    logic [31:0] cfg_pc = '0, cfg_bad = '0;
    int cfg_good_at = 1, cfg_err_tx = 0;

    function automatic logic [31:0] img_word(input int i);
        return {8'hC3, 8'(i), 16'(i * 7 + 3)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    initial forever begin
        @(posedge clk);
        cyc++;
        if (img_en) img_rdata <= img_word(int'(img_addr));
    end

    initial forever begin
        @(negedge clk);
        cmd_ready = 1'b0; wd_ready = 1'b0; rsp_valid = 1'b0; rsp_err = 1'b0; rsp_data = '0;
        case (ph)
            0: if (cmd_valid && !rst) begin
                cmd_ready = 1'b1;
                cur = n_tx;
                if (cur < 64) begin
                    tx_wr[cur] = cmd_write; tx_addr[cur] = cmd_addr;
                    tx_cnt[cur] = int'(cmd_count); tx_cmd_cyc[cur] = cyc;
                end
                n_tx++;
                if (cmd_write && cmd_addr == A_RST) resets_seen++;
                if (!cmd_write && cmd_addr == A_PC) pc_reads++;
                left = int'(cmd_count); wi = 0;
                ph = cmd_write ? 1 : 2;
            end
            1: if (wd_valid) begin
                wd_ready = 1'b1;
                if (wi == 0 && cur < 64) tx_w0[cur] = wd_data;
                if (cur < 64 && tx_addr[cur] >= A_CFG &&
                    wd_data != img_word(int'(tx_addr[cur] - A_CFG) + wi)) data_bad++;
                wi++;
                if (wi == left) ph = 2;
            end
            default: begin
                rsp_valid = 1'b1;
                rsp_err = (cur + 1 == cfg_err_tx);
                if (cur < 64) begin
                    tx_rsp_cyc[cur] = cyc;
                    if (tx_addr[cur] == A_PC) rsp_data = cfg_pc;
                    else if (tx_addr[cur] == A_ST)
                        rsp_data = (resets_seen >= cfg_good_at) ? GOOD : cfg_bad;
                end
                ph = 0;
            end
        endcase
    end

    task automatic run(input vec_t v, input bit extra_start, output bit got_done, output bit got_err);
        cfg_pc = v.pc; cfg_bad = v.bad; cfg_good_at = int'(v.good_at); cfg_err_tx = int'(v.err_tx);
        n_tx = 0; resets_seen = 0; pc_reads = 0; data_bad = 0;
        got_done = 1'b0; got_err = 1'b0;
        @(negedge clk);
        img_len = (IAW+1)'(v.len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 20000 && !got_done && !got_err; k++) begin
            @(posedge clk); #1;
            if (extra_start && k == 30) begin
                @(negedge clk); start = 1'b1;
                @(negedge clk); start = 1'b0;
            end
            if (done) got_done = 1'b1;
            if (error) got_err = 1'b1;
        end
    endtask

    task automatic check_vec(input vec_t v, input bit got_done, input bit got_err);
        int r, j, off, c, first_rst;
        bit geom_ok, rst_ok;
        int n_before;
        chk(got_err == v.exp_err && got_done == !v.exp_err,
            v.exp_err ? (v.exp_att == 0 ? "R10" : "R9") : "R7", "outcome error flag",
            got_err, v.exp_err);
        chk(attempts == v.exp_att[3:0], "R8", "attempts used", attempts, v.exp_att);
        if (v.exp_att != 0) begin
            chk(tx_w0[1] == (v.pc | 32'h1F) && tx_wr[1] && tx_addr[1] == A_PC && !tx_wr[0],
                "R1", "port-control write data", tx_w0[1], v.pc | 32'h1F);
            chk(pc_reads == 1 && resets_seen == int'(v.exp_att), "R8",
                "reset writes per run", resets_seen, v.exp_att);
            first_rst = 2;
            chk(tx_cmd_cyc[first_rst] - tx_rsp_cyc[1] >= DRAIN_CYC, "R2", "drain gap",
                tx_cmd_cyc[first_rst] - tx_rsp_cyc[1], DRAIN_CYC);
            rst_ok = 1'b1;
            for (int t = 0; t < n_tx && t < 64; t++)
                if (tx_wr[t] && tx_addr[t] == A_RST && (tx_w0[t] != 32'h8 || tx_cnt[t] != 1))
                    rst_ok = 1'b0;
            chk(rst_ok, "R3", "reset word is bit 3 only", rst_ok, 1);
        end else begin
            chk(n_tx == 1 && resets_seen == 0, "R10", "commands after inhibit error", n_tx, 1);
        end
        if (!v.exp_err) begin
            r = 0;
            for (int t = 0; t < n_tx && t < 64; t++)
                if (tx_wr[t] && tx_addr[t] == A_RST) r = t;
            chk(tx_cmd_cyc[r+1] - tx_rsp_cyc[r] >= RESET_CYC, "R4", "reset wait gap",
                tx_cmd_cyc[r+1] - tx_rsp_cyc[r], RESET_CYC);
            geom_ok = 1'b1; j = r + 1; off = 0;
            while (off < int'(v.len)) begin
                c = (int'(v.len) - off > CMAX) ? CMAX : int'(v.len) - off;
                if (!tx_wr[j] || tx_addr[j] != A_CFG + 24'(off) || tx_cnt[j] != c) geom_ok = 1'b0;
                j++; off += c;
            end
            if (tx_wr[j] || tx_addr[j] != A_ST || j != n_tx - 1) geom_ok = 1'b0;
            chk(geom_ok, "R5", "burst plan of final attempt", n_tx, j + 1);
            chk(data_bad == 0, "R6", "image words mismatching", data_bad, 0);
        end
        n_before = n_tx;
        repeat (20) @(posedge clk);
        #1;
        chk(attempts == v.exp_att[3:0] && n_tx == n_before && !cmd_valid && !busy, "R11",
            "attempts held and bus idle after completion", attempts, v.exp_att);
    endtask

    initial begin
        bit gd, ge;
        repeat (3) @(posedge clk);
        #1;
        chk(!busy && !done && !error && attempts == 0 && !cmd_valid && !wd_valid, "R13",
            "outputs under reset", {busy, done, error, cmd_valid, wd_valid}, 0);
        @(negedge clk); rst = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk(!busy && attempts == 0 && !cmd_valid, "R13", "idle after reset", busy, 0);

        for (int i = 0; i < NV; i++) begin
            run(VECS[i], 1'b0, gd, ge);
            check_vec(VECS[i], gd, ge);
        end

        // start pulse while busy must not restart the sequence
        run(VECS[0], 1'b1, gd, ge);
        chk(gd && pc_reads == 1 && n_tx == 7, "R12", "transactions with extra start", n_tx, 7);
        repeat (100) @(posedge clk);
        #1;
        chk(!busy && n_tx == 7 && !cmd_valid, "R14", "bus quiet when idle", n_tx, 7);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        #(150_000 * 5);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule